// File: doc/BRIEF.md
# Frame Length Filter

The block sits on the receive path of a switch and measures each incoming frame on a byte-per-beat stream. A beat is qualified by `rx_valid`. `rx_sof` opens a frame and `rx_eof` closes it. The length counted is the whole frame on the wire: header, any VLAN tag and the frame check sequence.

When the closing beat arrives, the block compares the length against two bounds. Frames shorter than a minimum are flagged as runts. Frames longer than a ceiling are flagged as oversize. Both kinds are dropped. Two shared size-control bits choose the ceiling from three values: a standard tagged-frame limit, a slightly larger override limit, and a jumbo limit. One setting serves every port that uses the filter.

The setting is captured when a frame opens, so software can change it at any time without splitting a frame between two limits. A saturating counter totals oversize drops and is zeroed by a clear pulse.

Top module: `frame_len_gate`

## Requirements
- R1: Frame length is the number of beats with `rx_valid` high from the opening beat (`rx_sof`) through the closing beat (`rx_eof`), inclusive. Cycles with `rx_valid` low inside a frame add nothing.
- R2: With `cfg_huge`=0 and `cfg_legal`=0, frames of length up to LIM_STD (default 1522) are accepted and longer ones are flagged oversize.
- R3: With `cfg_huge`=0 and `cfg_legal`=1, frames up to LIM_LEGAL (default 1536) are accepted and longer ones are flagged oversize.
- R4: With `cfg_huge`=1, frames up to LIM_HUGE (default 1916) are accepted whatever `cfg_legal` is, and longer ones are flagged oversize.
- R5: Frames shorter than MIN_LEN (default 64) are flagged runt and dropped. A runt never counts toward `drop_count`.
- R6: The size setting is sampled on the opening beat. Changing `cfg_huge` or `cfg_legal` later in the frame does not alter that frame's verdict.
- R7: The cycle after the closing beat, `verdict_valid` is high and exactly one of `verdict_accept`, `verdict_runt`, `verdict_oversize` is high. `verdict_drop` is high exactly when runt or oversize is. With no closing beat in the previous cycle, all five outputs are low.
- R8: `drop_count` rises by one in the same cycle as each oversize verdict. It saturates at all ones (CNT_W bits, default 16) and never wraps.
- R9: A high `drop_cnt_clr` zeroes `drop_count` at the next edge. The clear wins over an oversize verdict in the same cycle.
- R10: Beats with `rx_valid` high outside a frame (no open `rx_sof`) are ignored, including stray `rx_eof`: no verdict follows them. An `rx_sof` inside an open frame restarts the count at 1.
- R11: The internal length saturates at 2^LEN_W-1. A frame of any greater length is still flagged oversize and is never accepted by wrap-around.
- R12: After reset, `drop_count` is 0, all verdict outputs are low, and the standard ceiling applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Beat qualifier, one byte per beat |
| rx_sof | input | 1 | Opening beat of a frame |
| rx_eof | input | 1 | Closing beat of a frame |
| cfg_huge | input | 1 | Selects the jumbo ceiling |
| cfg_legal | input | 1 | Selects the override ceiling when `cfg_huge` is low |
| drop_cnt_clr | input | 1 | Clear pulse for the drop counter |
| verdict_valid | output | 1 | Verdict strobe, one cycle after the closing beat |
| verdict_accept | output | 1 | Frame length within bounds |
| verdict_drop | output | 1 | Frame dropped (runt or oversize) |
| verdict_runt | output | 1 | Frame shorter than the minimum |
| verdict_oversize | output | 1 | Frame longer than the captured ceiling |
| drop_count | output | CNT_W | Saturating count of oversize drops |

## Verification
The hardest conditions to reach from the ports are the two saturation points: the length counter running past 2^LEN_W-1, and the drop counter reaching all ones. At the default widths, the second alone would take tens of millions of cycles. The bench therefore drives a second, narrow copy of the filter (5-bit length, 3-bit counter, ceilings of 10/12/20 beats) from the same stimulus. On that copy it sweeps every length from 1 to 34 under all four settings, so both saturation points and every ceiling edge are reached. The default copy is exercised at the exact ceiling boundaries and at a frame longer than 4095 beats. Setting flips in mid-frame and clears that coincide with a closing beat are placed at chosen beats.

// File: rtl/flf_pkg.sv
package flf_pkg;

   typedef enum logic [1:0] {
      SZ_STD   = 2'd0,
      SZ_LEGAL = 2'd1,
      SZ_HUGE  = 2'd2
   } size_mode_e;

   // huge dominates; legal only matters when huge is clear
   function automatic size_mode_e decode_mode(input logic huge, input logic legal);
      if (huge)       return SZ_HUGE;
      else if (legal) return SZ_LEGAL;
      else            return SZ_STD;
   endfunction

endpackage

// File: rtl/flf_limit_sel.sv
module flf_limit_sel
   import flf_pkg::*;
#(
   parameter int LEN_W     = 12,
   parameter int LIM_STD   = 1522,
   parameter int LIM_LEGAL = 1536,
   parameter int LIM_HUGE  = 1916
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             cfg_huge,
   input  logic             cfg_legal,
   output logic [LEN_W-1:0] limit_now
);

   size_mode_e mode_q;
   size_mode_e mode_use;

   // on an opening beat the live setting applies at once
   assign mode_use = take ? decode_mode(cfg_huge, cfg_legal) : mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode_q <= SZ_STD;
      else if (take) mode_q <= decode_mode(cfg_huge, cfg_legal);
   end

   always_comb begin
      case (mode_use)
         SZ_HUGE:  limit_now = LEN_W'(LIM_HUGE);
         SZ_LEGAL: limit_now = LEN_W'(LIM_LEGAL);
         default:  limit_now = LEN_W'(LIM_STD);
      endcase
   end

endmodule

// File: rtl/flf_len_count.sv
module flf_len_count #(
   parameter int LEN_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_sof,
   input  logic             rx_eof,
   output logic             open_beat,
   output logic             close_beat,
   output logic [LEN_W-1:0] cur_len
);

   localparam logic [LEN_W-1:0] LEN_TOP = '1;

   logic             in_frame_q;
   logic [LEN_W-1:0] cnt_q;
   logic             live;

   assign live       = rx_valid && (rx_sof || in_frame_q);
   assign open_beat  = rx_valid && rx_sof;
   assign close_beat = live && rx_eof;

   always_comb begin
      if (rx_sof)                cur_len = LEN_W'(1);
      else if (cnt_q == LEN_TOP) cur_len = LEN_TOP;
      else                       cur_len = cnt_q + LEN_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         cnt_q      <= '0;
      end else if (live) begin
         in_frame_q <= !rx_eof;
         cnt_q      <= cur_len;
      end
   end

endmodule

// File: rtl/flf_judge.sv
module flf_judge #(
   parameter int LEN_W   = 12,
   parameter int MIN_LEN = 64
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             close_beat,
   input  logic [LEN_W-1:0] cur_len,
   input  logic [LEN_W-1:0] limit_now,
   output logic             over_evt,
   output logic             v_valid,
   output logic             v_accept,
   output logic             v_runt,
   output logic             v_over
);

   logic is_runt;
   logic is_over;

   generate
      if (MIN_LEN > 0) begin : g_runt
         assign is_runt = cur_len < LEN_W'(MIN_LEN);
      end else begin : g_no_runt
         assign is_runt = 1'b0;
      end
   endgenerate

   assign is_over  = !is_runt && (cur_len > limit_now);
   assign over_evt = close_beat && is_over;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_valid  <= 1'b0;
         v_accept <= 1'b0;
         v_runt   <= 1'b0;
         v_over   <= 1'b0;
      end else begin
         v_valid  <= close_beat;
         v_accept <= close_beat && !is_runt && !is_over;
         v_runt   <= close_beat && is_runt;
         v_over   <= close_beat && is_over;
      end
   end

endmodule

// File: rtl/flf_sat_cnt.sv
module flf_sat_cnt #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         count <= '0;
      else if (clr)                       count <= '0;
      else if (inc && (count != CNT_TOP)) count <= count + CNT_W'(1);
   end

endmodule

// File: rtl/frame_len_gate.sv
module frame_len_gate #(
   parameter int LEN_W     = 12,
   parameter int CNT_W     = 16,
   parameter int MIN_LEN   = 64,
   parameter int LIM_STD   = 1522,
   parameter int LIM_LEGAL = 1536,
   parameter int LIM_HUGE  = 1916
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_sof,
   input  logic             rx_eof,
   input  logic             cfg_huge,
   input  logic             cfg_legal,
   input  logic             drop_cnt_clr,
   output logic             verdict_valid,
   output logic             verdict_accept,
   output logic             verdict_drop,
   output logic             verdict_runt,
   output logic             verdict_oversize,
   output logic [CNT_W-1:0] drop_count
);

   localparam int LEN_CEIL = (1 << LEN_W) - 1;

   generate
      if (!(MIN_LEN >= 0 && MIN_LEN <= LIM_STD && LIM_STD < LIM_LEGAL
            && LIM_LEGAL < LIM_HUGE)) begin : g_bad_order
         $error("frame_len_gate: bounds must rise MIN_LEN <= STD < LEGAL < HUGE");
      end
      if (LIM_HUGE >= LEN_CEIL) begin : g_bad_width
         $error("frame_len_gate: LEN_W too narrow for the jumbo ceiling");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("frame_len_gate: CNT_W must be positive");
      end
   endgenerate

   logic             open_beat;
   logic             close_beat;
   logic [LEN_W-1:0] cur_len;
   logic [LEN_W-1:0] limit_now;
   logic             over_evt;

   flf_len_count #(.LEN_W(LEN_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_sof     (rx_sof),
      .rx_eof     (rx_eof),
      .open_beat  (open_beat),
      .close_beat (close_beat),
      .cur_len    (cur_len)
   );

   flf_limit_sel #(
      .LEN_W     (LEN_W),
      .LIM_STD   (LIM_STD),
      .LIM_LEGAL (LIM_LEGAL),
      .LIM_HUGE  (LIM_HUGE)
   ) u_limit (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (open_beat),
      .cfg_huge  (cfg_huge),
      .cfg_legal (cfg_legal),
      .limit_now (limit_now)
   );

   flf_judge #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .close_beat (close_beat),
      .cur_len    (cur_len),
      .limit_now  (limit_now),
      .over_evt   (over_evt),
      .v_valid    (verdict_valid),
      .v_accept   (verdict_accept),
      .v_runt     (verdict_runt),
      .v_over     (verdict_oversize)
   );

   assign verdict_drop = verdict_runt || verdict_oversize;

   flf_sat_cnt #(.CNT_W(CNT_W)) u_drops (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (drop_cnt_clr),
      .inc   (over_evt),
      .count (drop_count)
   );

endmodule

// File: rtl/flf_checker.sv
module flf_checker #(
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             drop_cnt_clr,
   input logic             verdict_valid,
   input logic             verdict_accept,
   input logic             verdict_drop,
   input logic             verdict_runt,
   input logic             verdict_oversize,
   input logic [CNT_W-1:0] drop_count
);

   localparam logic [CNT_W-1:0] TOP = '1;

   p_one_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_valid |-> $countones({verdict_accept, verdict_runt, verdict_oversize}) == 1);

   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !verdict_valid |-> !(verdict_accept || verdict_runt || verdict_oversize || verdict_drop));

   p_drop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_drop |-> !verdict_accept);

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt_clr |=> drop_count == '0);

   p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count == TOP && !drop_cnt_clr) |=> drop_count == TOP);

   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_cnt_clr |=> (drop_count == $past(drop_count)
                         || drop_count == $past(drop_count) + CNT_W'(1)));

   p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_cnt_clr |=> (drop_count == $past(drop_count) || verdict_oversize));

endmodule

bind frame_len_gate flf_checker #(.CNT_W(CNT_W)) i_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .drop_cnt_clr     (drop_cnt_clr),
   .verdict_valid    (verdict_valid),
   .verdict_accept   (verdict_accept),
   .verdict_drop     (verdict_drop),
   .verdict_runt     (verdict_runt),
   .verdict_oversize (verdict_oversize),
   .drop_count       (drop_count)
);

// File: tb/test_frame_len_gate.sv
module test_frame_len_gate;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic cfg_huge = 1'b0, cfg_legal = 1'b0, drop_cnt_clr = 1'b0;

   logic        d_v, d_acc, d_drop, d_runt, d_over;
   logic [15:0] d_cnt;
   logic        s_v, s_acc, s_drop, s_runt, s_over;
   logic [2:0]  s_cnt;

   int checks = 0, fails = 0;
   int exp_d = 0, exp_s = 0;
   bit done = 0;

   always #5 clk = ~clk;

   frame_len_gate i_frame_len_gate (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .cfg_huge(cfg_huge), .cfg_legal(cfg_legal), .drop_cnt_clr(drop_cnt_clr),
      .verdict_valid(d_v), .verdict_accept(d_acc), .verdict_drop(d_drop),
      .verdict_runt(d_runt), .verdict_oversize(d_over), .drop_count(d_cnt));

   frame_len_gate #(.LEN_W(5), .CNT_W(3), .MIN_LEN(4), .LIM_STD(10),
                    .LIM_LEGAL(12), .LIM_HUGE(20)) i_frame_len_gate_sm (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .cfg_huge(cfg_huge), .cfg_legal(cfg_legal), .drop_cnt_clr(drop_cnt_clr),
      .verdict_valid(s_v), .verdict_accept(s_acc), .verdict_drop(s_drop),
      .verdict_runt(s_runt), .verdict_oversize(s_over), .drop_count(s_cnt));

   // 0 accept, 1 runt, 2 oversize
   function automatic int klass(int len, bit h, bit l, int mn, int ls, int ll, int lh, int top);
      int eff = (len > top) ? top : len;
      int lim = h ? lh : (l ? ll : ls);
      if (eff < mn)  return 1;
      if (eff > lim) return 2;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic beat(input logic s, input logic e);
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = s; rx_eof = e;
   endtask

   task automatic idle();
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; drop_cnt_clr = 1'b0;
   endtask

   // drives a frame; flip_at>=0 changes the setting before that beat
   task automatic frame(input int len, input bit holes, input int flip_at,
                        input bit fh, input bit fl, input bit clr_eof);
      for (int i = 0; i < len; i++) begin
         if (i == flip_at) begin cfg_huge = fh; cfg_legal = fl; end
         beat(i == 0, i == len - 1);
         if (clr_eof && i == len - 1) drop_cnt_clr = 1'b1;
         if (holes && i == 1 && len > 2) begin idle(); idle(); end
      end
      idle();
   endtask

   // compares both copies one cycle after the closing beat
   task automatic judge(input int len, input bit h, input bit l, input string req);
      int kd = klass(len, h, l, 64, 1522, 1536, 1916, 4095);
      int ks = klass(len, h, l, 4, 10, 12, 20, 31);
      if (kd == 2 && exp_d < 65535) exp_d++;
      if (ks == 2 && exp_s < 7) exp_s++;
      chk(d_v && d_acc == (kd == 0) && d_runt == (kd == 1) && d_over == (kd == 2)
          && d_drop == (kd != 0), req, {d_v, d_acc, d_runt, d_over}, kd);
      chk(s_v && s_acc == (ks == 0) && s_runt == (ks == 1) && s_over == (ks == 2)
          && s_drop == (ks != 0), req, {s_v, s_acc, s_runt, s_over}, ks);
      chk(d_cnt == exp_d, "R8 default count", d_cnt, exp_d);
      chk(s_cnt == exp_s, "R8 narrow count", s_cnt, exp_s);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int lens [9] = '{63, 64, 1522, 1523, 1536, 1537, 1916, 1917, 4100};
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(!d_v && !s_v && !d_acc && !d_drop && d_cnt == 0 && s_cnt == 0,
          "R12 reset", d_cnt, 0);
      rst_n = 1'b1;
      idle();

      // narrow sweep: R1 holes, R2-R5 and R11 (34 > 31) on the small copy
      for (int m = 0; m < 4; m++) begin
         cfg_huge = m[1]; cfg_legal = m[0];
         for (int n = 1; n <= 34; n++) begin
            frame(n, 1'b1, -1, 1'b0, 1'b0, 1'b0);
            judge(n, m[1], m[0], "R1/R2/R3/R4/R5/R11 sweep");
         end
      end

      // R10: stray beats and a stray closing beat give no verdict
      for (int i = 0; i < 4; i++) begin
         beat(1'b0, i == 3);
         chk(!d_v && !s_v, "R10 stray beat", s_v, 0);
      end
      idle();
      chk(!d_v && !s_v, "R10 stray close", s_v, 0);
      idle();

      // R10: opening beat inside an open frame restarts the count
      cfg_huge = 1'b0; cfg_legal = 1'b0;
      for (int i = 0; i < 8; i++) beat(i == 0, 1'b0);
      frame(5, 1'b0, -1, 1'b0, 1'b0, 1'b0);
      judge(5, 1'b0, 1'b0, "R10 restart");

      // R6: setting flips mid-frame leave the verdict unchanged
      frame(15, 1'b0, 4, 1'b1, 1'b0, 1'b0);
      judge(15, 1'b0, 1'b0, "R6 widen mid-frame");
      frame(15, 1'b0, 4, 1'b0, 1'b0, 1'b0);
      judge(15, 1'b1, 1'b0, "R6 narrow mid-frame");
      frame(15, 1'b0, -1, 1'b0, 1'b0, 1'b0);
      judge(15, 1'b0, 1'b0, "R6 next frame");

      // R9: plain clear, then clear coinciding with an oversize verdict
      @(negedge clk); drop_cnt_clr = 1'b1;
      idle();
      exp_d = 0; exp_s = 0;
      chk(d_cnt == 0 && s_cnt == 0, "R9 clear", s_cnt, 0);
      frame(3, 1'b0, -1, 1'b0, 1'b0, 1'b0);
      judge(3, 1'b0, 1'b0, "R5 runt not counted");
      frame(2000, 1'b0, -1, 1'b0, 1'b0, 1'b1);
      chk(d_over && s_over, "R9 coincident verdict", s_over, 1);
      chk(d_cnt == 0 && s_cnt == 0, "R9 clear wins", d_cnt, 0);

      // default-size boundaries in all four settings; R8 narrow saturation
      for (int m = 0; m < 4; m++) begin
         cfg_huge = m[1]; cfg_legal = m[0];
         foreach (lens[k]) begin
            frame(lens[k], 1'b0, -1, 1'b0, 1'b0, 1'b0);
            judge(lens[k], m[1], m[0], "R2/R3/R4/R5/R11 default bounds");
         end
      end
      chk(s_cnt == 3'd7, "R8 narrow saturated", s_cnt, 7);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule